// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a byte-wide serial memory. A system clock much faster than the bus clock samples the serial clock and data lines through a short synchroniser. From the samples the block sees the two framing conditions and the clock edges, and it runs the transfer as a slave.

A transfer opens with a select byte. The select byte is compared with a fixed five-bit prefix and with two strap inputs. For a write, two word-address bytes follow and then data bytes. Each data byte goes to the memory as a single-cycle write strobe, and the word pointer advances after each one. For a read, the block fetches the byte at the word pointer and shifts it out MSB first. It keeps streaming successive bytes for as long as the master acknowledges.

The data line is open drain: the block only asserts an enable that pulls the line low. While an internal program cycle is busy, the block refuses its own select byte.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling edge of SDA while SCL is high (START) is honoured from every state, including the middle of a byte. It abandons the transfer and starts capture of a new select byte.
- R2: A rising edge of SDA while SCL is high (STOP) returns the block to idle with SDA released. Bytes clocked after a STOP and before the next START get no acknowledge and cause no memory strobe.
- R3: The select byte arrives MSB first. Bits 7:3 must be 10100, bits 2:1 must equal `strap_sel[1:0]`, and bit 0 is 1 for read and 0 for write. On a match, `sda_oe` is high through the ninth SCL pulse. On a mismatch, nothing is acknowledged until the next START.
- R4: If `prog_busy` is high when the select byte completes, the select byte is not acknowledged.
- R5: After a write select, the next two bytes load the word pointer, high byte first. Bit 7 of the high byte is ignored, and every received byte is acknowledged.
- R6: Every later write byte gives exactly one cycle of `mem_wr`, with `mem_addr` at the word pointer and `mem_wdata` equal to the byte. The pointer then advances by one.
- R7: A read select gives one `mem_rd` cycle at the word pointer, and the pointer then advances. `mem_rdata` is taken in the cycle after `mem_rd`. Bits are sent MSB first, with `sda_oe` high for a 0 bit. `mem_rd` and `mem_wr` are never high together.
- R8: During a read, a low level on SDA at the ninth SCL pulse fetches and sends the next byte. A high level releases SDA and stops all fetching until START or STOP, and it leaves the pointer just past the last byte sent.
- R9: The 15-bit word pointer wraps from 0x7FFF to 0x0000 in both writes and reads.
- R10: SCL and SDA pass through a two-flop synchroniser. `sda_oe` changes only after a synchronised SCL fall or a framing condition, never in the middle of an SCL high phase.
- R11: While reset is asserted, `sda_oe`, `mem_rd`, `mem_wr` and `mem_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe | output | 1 | High pulls the data line low |
| strap_sel | input | 2 | Strap value compared with select bits 2:1 |
| prog_busy | input | 1 | High while the memory's program cycle runs |
| mem_addr | output | 15 | Word pointer presented to the memory |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write, valid with `mem_wr` |
| mem_rdata | input | 8 | Read byte, valid in the cycle after `mem_rd` |

## Verification
A change on SCL reaches the synchroniser output two clocks later, and the edge flag is high in that cycle. `sda_oe`, `mem_wr` and `mem_rd` register one clock after that, so they move three clocks after the pad edge. The word pointer moves one clock after a strobe, and read data is captured two clocks after `mem_rd`. The bench holds each SCL phase for twelve clocks and samples the bus in the middle of each high phase, so every acknowledge and data bit it checks has long settled. On every clock it compares the memory strobes with queues of expected address and data, and it flags any `sda_oe` change later than four clocks into an SCL high phase.

// File: rtl/serial_mem_slave_pkg.sv
package serial_mem_slave_pkg;

  // Fixed upper five bits of the select byte.
  localparam logic [4:0] SEL_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until START
    ST_SEL,    // shifting in the select byte
    ST_AHI,    // word address, high byte
    ST_ALO,    // word address, low byte
    ST_WDAT,   // write data bytes
    ST_RDAT,   // read data bytes
    ST_HOLD    // master declined, wait for framing
  } bus_st_e;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh_q;
  logic [STAGES-1:0] sda_sh_q;
  logic              scl_prev_q;
  logic              sda_prev_q;
  logic              scl_now;

  // Idle bus is high, so the chain resets high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_raw};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_raw};
      scl_prev_q <= scl_sh_q[STAGES-1];
      sda_prev_q <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_now   = scl_sh_q[STAGES-1];
  assign sda_lvl   = sda_sh_q[STAGES-1];
  assign scl_rise  = scl_now & ~scl_prev_q;
  assign scl_fall  = ~scl_now & scl_prev_q;
  assign start_det = scl_now & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_now & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/word_ptr.sv
module word_ptr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) begin
      ptr_d = load_val;
    end else if (step_en) begin
      ptr_d = ptr_q + {{(AW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_en || step_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && (ptr_q == '1)) |=> (ptr_q == '0));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import serial_mem_slave_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [1:0]    strap,
  input  logic          prog_busy,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    wdata,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_load_val,
  output logic          ptr_step
);

  localparam int          HI_W    = AW - 8;
  localparam logic [3:0]  BIT_ACK = 4'd8;
  localparam logic [3:0]  BIT_END = 4'd9;

  bus_st_e         st_q, st_d;
  logic [3:0]      cnt_q, cnt_d;
  logic [7:0]      rx_q, rx_d;
  logic [7:0]      tx_q, tx_d;
  logic [7:0]      buf_q, buf_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            oe_q, oe_d;
  logic            rd_q, rd_d;
  logic            wr_q, wr_d;
  logic            cap_q;
  logic            rnw_q, rnw_d;
  logic            mack_q, mack_d;
  logic            sel_hit;
  logic            rx_phase;

  assign sel_hit  = (rx_q[7:3] == SEL_PREFIX) && (rx_q[2:1] == strap) && !prog_busy;
  assign rx_phase = (st_q == ST_SEL) || (st_q == ST_AHI) ||
                    (st_q == ST_ALO) || (st_q == ST_WDAT);

  // Next-state logic
  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    rx_d         = rx_q;
    tx_d         = tx_q;
    hi_d         = hi_q;
    oe_d         = oe_q;
    rd_d         = 1'b0;
    wr_d         = 1'b0;
    rnw_d        = rnw_q;
    mack_d       = mack_q;
    buf_d        = cap_q ? rdata : buf_q;
    ptr_load     = 1'b0;
    ptr_load_val = {hi_q, rx_q};

    if (start_det) begin
      st_d  = ST_SEL;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (rx_phase) begin
      if (scl_rise) begin
        if (cnt_q < BIT_ACK) begin
          rx_d  = {rx_q[6:0], sda_lvl};
          cnt_d = cnt_q + 4'd1;
        end else if (cnt_q == BIT_ACK) begin
          cnt_d = BIT_END;
        end
      end
      if (scl_fall && (cnt_q == BIT_ACK)) begin
        oe_d = 1'b1;
        case (st_q)
          ST_SEL: begin
            if (sel_hit) begin
              rnw_d = rx_q[0];
              rd_d  = rx_q[0];
            end else begin
              oe_d  = 1'b0;
              st_d  = ST_IDLE;
              cnt_d = '0;
            end
          end
          ST_AHI:  hi_d     = rx_q[HI_W-1:0];
          ST_ALO:  ptr_load = 1'b1;
          default: wr_d     = 1'b1;
        endcase
      end else if (scl_fall && (cnt_q == BIT_END)) begin
        oe_d  = 1'b0;
        cnt_d = '0;
        case (st_q)
          ST_SEL: begin
            if (rnw_q) begin
              st_d = ST_RDAT;
              tx_d = buf_q;
              oe_d = ~buf_q[7];
            end else begin
              st_d = ST_AHI;
            end
          end
          ST_AHI:  st_d = ST_ALO;
          default: st_d = ST_WDAT;
        endcase
      end
    end else if (st_q == ST_RDAT) begin
      if (scl_rise) begin
        if (cnt_q < BIT_ACK) begin
          cnt_d = cnt_q + 4'd1;
        end else if (cnt_q == BIT_ACK) begin
          cnt_d  = BIT_END;
          mack_d = ~sda_lvl;
          rd_d   = ~sda_lvl;
        end
      end
      if (scl_fall) begin
        if ((cnt_q >= 4'd1) && (cnt_q < BIT_ACK)) begin
          tx_d = {tx_q[6:0], 1'b0};
          oe_d = ~tx_q[6];
        end else if (cnt_q == BIT_ACK) begin
          oe_d = 1'b0;
        end else if (cnt_q == BIT_END) begin
          cnt_d = '0;
          if (mack_q) begin
            tx_d = buf_q;
            oe_d = ~buf_q[7];
          end else begin
            st_d = ST_HOLD;
            oe_d = 1'b0;
          end
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      buf_q  <= '0;
      hi_q   <= '0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      cap_q  <= 1'b0;
      rnw_q  <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      buf_q  <= buf_d;
      hi_q   <= hi_d;
      oe_q   <= oe_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cap_q  <= rd_q;
      rnw_q  <= rnw_d;
      mack_q <= mack_d;
    end
  end

  assign sda_oe   = oe_q;
  assign mem_rd   = rd_q;
  assign mem_wr   = wr_q;
  assign wdata    = rx_q;
  assign ptr_step = rd_q | wr_q;

  // R4
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SEL) && scl_fall && (cnt_q == BIT_ACK) && prog_busy) |=> !sda_oe);

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> (!sda_oe && !mem_rd));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int AW          = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    strap_sel,
  input  logic          prog_busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          sda_lvl;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          ptr_load;
  logic [AW-1:0] ptr_load_val;
  logic          ptr_step;

  // Asserted at once, released after two clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  bus_sampler #(
    .STAGES (SYNC_STAGES)
  ) sampler_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  xfer_engine #(
    .AW (AW)
  ) engine_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sda_lvl      (sda_lvl),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .strap        (strap_sel),
    .prog_busy    (prog_busy),
    .rdata        (mem_rdata),
    .sda_oe       (sda_oe),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .wdata        (mem_wdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_step     (ptr_step)
  );

  word_ptr #(
    .AW (AW)
  ) ptr_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (ptr_load),
    .load_val (ptr_load_val),
    .step_en  (ptr_step),
    .ptr      (mem_addr)
  );

endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;

  localparam int Q = 6;

  logic        clk;
  logic        rst_n;
  logic        m_scl;
  logic        m_sda;
  logic        sda_oe;
  logic        sda_bus;
  logic [1:0]  strap;
  logic        busy;
  logic [14:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int fails  = 0;
  int r10_bad = 0;
  int scl_hi_cnt = 0;
  logic prev_oe = 1'b0;

  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  int         exp_wa [$];
  logic [7:0] exp_wd [$];
  int         exp_ra [$];

  assign sda_bus = m_sda & ~sda_oe;

  serial_mem_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .strap_sel (strap),
    .prog_busy (busy),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] fill_pat(int a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return fill_pat(a);
  endfunction

  // Memory model: registered read, one cycle latency.
  always @(posedge clk) begin
    if (mem_wr) dev_mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= dev_mem.exists(int'(mem_addr)) ?
                             dev_mem[int'(mem_addr)] : fill_pat(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of strobes and SDA enable timing.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) begin
        if (exp_wa.size() == 0) chk(1'b0, "R6 unexpected mem_wr", int'(mem_addr), -1);
        else begin
          int a;
          logic [7:0] d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          chk(int'(mem_addr) == a && mem_wdata == d, "R6 write strobe",
              {mem_addr, mem_wdata}, {a[14:0], d});
        end
      end
      if (mem_rd) begin
        if (exp_ra.size() == 0) chk(1'b0, "R7 unexpected mem_rd", int'(mem_addr), -1);
        else begin
          int a;
          a = exp_ra.pop_front();
          chk(int'(mem_addr) == a, "R7 read strobe address", int'(mem_addr), a);
        end
      end
      if (m_scl) scl_hi_cnt++;
      else scl_hi_cnt = 0;
      if (scl_hi_cnt > 4 && sda_oe != prev_oe) r10_bad++;
      prev_oe = sda_oe;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input bit drive, output bit seen);
    m_sda = drive;
    wait_clk(Q);
    m_scl = 1'b1;
    wait_clk(Q);
    seen = sda_bus;
    wait_clk(Q);
    m_scl = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    wait_clk(Q);
    m_scl = 1'b1;
    wait_clk(Q);
    m_sda = 1'b0;
    wait_clk(Q);
    m_scl = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    wait_clk(Q);
    m_scl = 1'b1;
    wait_clk(Q);
    m_sda = 1'b1;
    wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_slot(1'b1, s);
      b = {b[6:0], s};
    end
    bit_slot(!give_ack, s);
  endtask

  task automatic queue_write(input int a, input logic [7:0] d);
    exp_wa.push_back(a);
    exp_wd.push_back(d);
    ref_mem[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, all requirements");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    strap = 2'b10;
    busy  = 1'b0;
    wait_clk(5);
    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda_oe in reset", sda_oe, 0);
    chk(!mem_rd && !mem_wr, "R11 strobes in reset", {mem_rd, mem_wr}, 0);
    chk(mem_addr == 15'h0, "R11 mem_addr in reset", mem_addr, 0);
    rst_n = 1'b1;
    wait_clk(10);

    // R5 / R6: write three bytes at 0x1234, high byte carries a set MSB
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R3 write select ack", ack, 1);
    send_byte(8'h92, ack); chk(ack, "R5 high address ack", ack, 1);
    send_byte(8'h34, ack); chk(ack, "R5 low address ack", ack, 1);
    queue_write(32'h1234, 8'hA1);
    queue_write(32'h1235, 8'hB2);
    queue_write(32'h1236, 8'hC3);
    send_byte(8'hA1, ack); chk(ack, "R6 data ack", ack, 1);
    send_byte(8'hB2, ack); chk(ack, "R6 data ack", ack, 1);
    send_byte(8'hC3, ack); chk(ack, "R6 data ack", ack, 1);
    bus_stop();
    chk(mem_addr == 15'h1237, "R6 pointer after writes", mem_addr, 32'h1237);

    // R1 / R7 / R8: random read through a repeated START
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R3 select ack", ack, 1);
    send_byte(8'h12, ack);
    send_byte(8'h35, ack);
    bus_start();
    exp_ra.push_back(32'h1235);
    exp_ra.push_back(32'h1236);
    send_byte(8'hA5, ack); chk(ack, "R1 repeated START read select ack", ack, 1);
    recv_byte(1'b1, rb); chk(rb == ref_rd(32'h1235), "R7 first read byte", rb, ref_rd(32'h1235));
    recv_byte(1'b0, rb); chk(rb == ref_rd(32'h1236), "R8 sequential byte", rb, ref_rd(32'h1236));
    bus_stop();
    chk(mem_addr == 15'h1237, "R8 pointer after NACK", mem_addr, 32'h1237);

    // R8 current address read
    exp_ra.push_back(32'h1237);
    bus_start();
    send_byte(8'hA5, ack); chk(ack, "R7 read select ack", ack, 1);
    recv_byte(1'b0, rb); chk(rb == ref_rd(32'h1237), "R8 current address byte", rb, ref_rd(32'h1237));
    bus_stop();

    // R3 strap mismatch and prefix mismatch
    bus_start();
    send_byte(8'hA2, ack); chk(!ack, "R3 strap mismatch no ack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hE4, ack); chk(!ack, "R3 prefix mismatch no ack", ack, 0);
    bus_stop();

    // R4 busy refuses select
    busy = 1'b1;
    bus_start();
    send_byte(8'hA4, ack); chk(!ack, "R4 busy no ack", ack, 0);
    bus_stop();
    busy = 1'b0;

    // R9 write wrap
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R4 ack after busy clears", ack, 1);
    send_byte(8'h7F, ack);
    send_byte(8'hFF, ack);
    queue_write(32'h7FFF, 8'h11);
    queue_write(32'h0000, 8'h22);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    chk(mem_addr == 15'h0001, "R9 pointer after write wrap", mem_addr, 1);

    // R9 read wrap
    bus_start();
    send_byte(8'hA4, ack);
    send_byte(8'h7F, ack);
    send_byte(8'hFF, ack);
    bus_start();
    exp_ra.push_back(32'h7FFF);
    exp_ra.push_back(32'h0000);
    send_byte(8'hA5, ack);
    recv_byte(1'b1, rb); chk(rb == 8'h11, "R9 read at top", rb, 8'h11);
    recv_byte(1'b0, rb); chk(rb == 8'h22, "R9 read after wrap", rb, 8'h22);
    bus_stop();

    // R2 byte after STOP without START
    send_byte(8'hA4, ack); chk(!ack, "R2 no ack without START", ack, 0);
    bus_stop();

    // R1 START in the middle of a byte
    bus_start();
    send_byte(8'hA4, ack);
    send_byte(8'h00, ack);
    for (int i = 0; i < 4; i++) begin
      bit s;
      bit_slot(i[0], s);
    end
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R1 ack after mid-byte START", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    bus_stop();
    chk(mem_addr == 15'h0010, "R1 address after abort", mem_addr, 32'h10);

    wait_clk(20);
    chk(exp_wa.size() == 0, "R6 missing writes", exp_wa.size(), 0);
    chk(exp_ra.size() == 0, "R7 missing reads", exp_ra.size(), 0);
    chk(r10_bad == 0, "R10 sda_oe moved during SCL high", r10_bad, 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule